// File: doc/BRIEF.md
# Mixed-Radix Lookahead Carry Tree

This block turns a word of bit-propagate and bit-generate signals plus one carry-in into the complete set of carries for that word, c[0] through c[M]. It is meant to sit between the per-bit propagate/generate logic of an adder and its sum XORs. The carries are formed by a tree of lookahead group nodes. Each node reduces its inputs to a group propagate and a group generate, passes them one level up, and later receives a carry from its parent and expands it into one carry per input.

The tree radix is a parameter. When the word width is not a power of the radix, each level uses as many full-radix nodes as fit and one narrower node for whatever is left over, so no node ever sees constant-zero padding. The shape is fixed at elaboration by constant functions. The carries leave through one register stage with a synchronous active-high reset.

Top module: `hlc_carry_tree`

## Requirements
- R1: While `rst` is high at a rising edge, `carry_o` becomes all zeros after that edge.
- R2: `carry_o[0]` equals the `cin_i` value sampled at the previous rising edge.
- R3: Bit i of `prop_i` and of `gen_i` (LSB is bit 0) belong to bit position i. For every i below WIDTH, `carry_o[i+1]` equals `gen_i[i] | (prop_i[i] & c[i])`, where c[i] is the carry at position i. The inputs are those sampled at the previous rising edge, so the latency is one cycle.
- R4: With every propagate bit set and no generate bit set, every bit of `carry_o` equals the previous cycle's carry-in.
- R5: With every generate bit set, `carry_o[WIDTH:1]` are all ones whatever the carry-in.
- R6: With no propagate and no generate bit set, `carry_o[WIDTH:1]` are all zeros whatever the carry-in.
- R7: The carry-out `carry_o[WIDTH]` is formed at the root from the root group signals and the carry-in. A generate at bit 0 with propagate on every higher bit therefore sets it.
- R8: Each level has floor(count/RADIX) full nodes plus one remainder node when the count is not a multiple of RADIX, and the tree has ceil(log_RADIX WIDTH) levels. The carries are correct both for a width that is not a power of the radix (14 bits, radix 3) and for one that is (64 bits, radix 8).
- R9: A remainder of exactly one signal at a level is forwarded unchanged as its own group. Carries stay correct for a shape that needs this (10 bits, radix 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prop_i | input | WIDTH | Per-bit propagate, bit i for position i |
| gen_i | input | WIDTH | Per-bit generate, bit i for position i |
| cin_i | input | 1 | Carry into position 0 |
| carry_o | output | WIDTH+1 | Registered carries c[0] to c[WIDTH] |

## Verification
On every cycle, the assertions check that each registered carry follows the one-bit recurrence from the previous cycle's inputs and the carry below it. They also check the pass-through of the carry-in, the all-propagate and all-generate cases, and the reset value. Only the bench's scenarios can show that different tree shapes give correct carries: a width that is a power of the radix, one that is not, and one whose levels leave a single-signal remainder. These shapes are exercised by three instances under shared random and directed propagate/generate patterns.

// File: rtl/hlc_pkg.sv
package hlc_pkg;

  // number of signals present at a given level of the tree (level 0 = bits)
  function automatic int lvl_cnt(input int width, input int radix, input int lvl);
    int c;
    c = width;
    for (int i = 0; i < lvl; i++)
      c = c / radix + (((c % radix) != 0) ? 1 : 0);
    return c;
  endfunction

  // number of node levels needed until a single signal remains
  function automatic int num_lvls(input int width, input int radix);
    int c;
    int l;
    c = width;
    l = 0;
    while (c > 1) begin
      c = c / radix + (((c % radix) != 0) ? 1 : 0);
      l++;
    end
    return l;
  endfunction

  // start index of a level inside the flattened signal store
  function automatic int lvl_off(input int width, input int radix, input int lvl);
    int s;
    s = 0;
    for (int i = 0; i < lvl; i++)
      s = s + lvl_cnt(width, radix, i);
    return s;
  endfunction

endpackage

// File: rtl/hlc_node.sv
module hlc_node #(
  parameter int W = 4
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  input  logic         cin_i,
  output logic         gp_o,
  output logic         gg_o,
  output logic [W-1:0] c_o
);

  // group propagate / generate in flat sum-of-products form
  always_comb begin
    logic term;
    gp_o = &p_i;
    gg_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      term = g_i[i];
      for (int j = i + 1; j < W; j++)
        term = term & p_i[j];
      gg_o = gg_o | term;
    end
  end

  // internal carries, each one computed directly from the node carry-in
  always_comb begin
    logic acc;
    logic term;
    for (int i = 0; i < W; i++) begin
      acc = cin_i;
      for (int j = 0; j < i; j++)
        acc = acc & p_i[j];
      for (int j = 0; j < i; j++) begin
        term = g_i[j];
        for (int k = j + 1; k < i; k++)
          term = term & p_i[k];
        acc = acc | term;
      end
      c_o[i] = acc;
    end
  end

endmodule

// File: rtl/hlc_tree.sv
module hlc_tree
  import hlc_pkg::*;
#(
  parameter int WIDTH = 14,
  parameter int RADIX = 3
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] g_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   c_o
);

  localparam int LEVELS = num_lvls(WIDTH, RADIX);
  localparam int TOTAL  = lvl_off(WIDTH, RADIX, LEVELS + 1);
  localparam int ROOT   = TOTAL - 1;

  // flattened per-level signal store: propagate, generate, incoming carry
  logic sp [TOTAL];
  logic sg [TOTAL];
  logic sc [TOTAL];

  for (genvar j = 0; j < WIDTH; j++) begin : g_leaf
    assign sp[j]  = p_i[j];
    assign sg[j]  = g_i[j];
    assign c_o[j] = sc[j];
  end

  assign sc[ROOT]  = cin_i;
  // carry-out at the root: one AND then one OR
  assign c_o[WIDTH] = sg[ROOT] | (sp[ROOT] & cin_i);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CNT    = lvl_cnt(WIDTH, RADIX, l);
    localparam int FULL   = CNT / RADIX;
    localparam int REM    = CNT % RADIX;
    localparam int NODES  = FULL + ((REM != 0) ? 1 : 0);
    localparam int IN_OFF = lvl_off(WIDTH, RADIX, l);
    localparam int UP_OFF = lvl_off(WIDTH, RADIX, l + 1);

    for (genvar k = 0; k < NODES; k++) begin : g_node
      localparam int NW   = (k < FULL) ? RADIX : REM;
      localparam int BASE = IN_OFF + k * RADIX;

      logic [NW-1:0] np;
      logic [NW-1:0] ng;
      logic [NW-1:0] nc;

      for (genvar b = 0; b < NW; b++) begin : g_pin
        assign np[b]        = sp[BASE + b];
        assign ng[b]        = sg[BASE + b];
        assign sc[BASE + b] = nc[b];
      end

      hlc_node #(.W(NW)) u_node (
        .p_i  (np),
        .g_i  (ng),
        .cin_i(sc[UP_OFF + k]),
        .gp_o (sp[UP_OFF + k]),
        .gg_o (sg[UP_OFF + k]),
        .c_o  (nc)
      );
    end
  end

endmodule

// File: rtl/hlc_carry_tree.sv
module hlc_carry_tree #(
  parameter int WIDTH = 14,
  parameter int RADIX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] gen_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   carry_o
);

  logic [WIDTH:0] carry_w;

  hlc_tree #(.WIDTH(WIDTH), .RADIX(RADIX)) u_tree (
    .p_i  (prop_i),
    .g_i  (gen_i),
    .cin_i(cin_i),
    .c_o  (carry_w)
  );

  always_ff @(posedge clk) begin
    if (rst) carry_o <= '0;
    else     carry_o <= carry_w;
  end

endmodule

// File: rtl/hlc_carry_tree_chk.sv
module hlc_carry_tree_chk #(
  parameter int WIDTH = 14
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] prop_i,
  input logic [WIDTH-1:0] gen_i,
  input logic             cin_i,
  input logic [WIDTH:0]   carry_o
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> carry_o == '0);

  p_cin_pass_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> carry_o[0] == $past(cin_i));

  for (genvar i = 0; i < WIDTH; i++) begin : g_step
    p_ripple_step_r3: assert property (@(posedge clk) disable iff (rst)
      !rst |=> carry_o[i+1] == ($past(gen_i[i]) | ($past(prop_i[i]) & carry_o[i])));
  end

  p_all_prop_r4: assert property (@(posedge clk) disable iff (rst)
    (&prop_i && gen_i == '0) |=> carry_o == {(WIDTH+1){$past(cin_i)}});

  p_all_gen_r5: assert property (@(posedge clk) disable iff (rst)
    (&gen_i) |=> &carry_o[WIDTH:1]);

  p_all_kill_r6: assert property (@(posedge clk) disable iff (rst)
    (prop_i == '0 && gen_i == '0) |=> carry_o[WIDTH:1] == '0);

endmodule

bind hlc_carry_tree hlc_carry_tree_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .prop_i (prop_i),
  .gen_i  (gen_i),
  .cin_i  (cin_i),
  .carry_o(carry_o)
);

// File: tb/sim_hlc_carry_tree.sv
module sim_hlc_carry_tree;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] p_in = '0;
  logic [63:0] g_in = '0;
  logic        c_in = 1'b0;

  logic [14:0] c0;
  logic [64:0] c1;
  logic [10:0] c2;

  int n_check = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // 14 bits, radix 3: not a power of the radix
  hlc_carry_tree #(.WIDTH(14), .RADIX(3)) u0 (
    .clk(clk), .rst(rst), .prop_i(p_in[13:0]), .gen_i(g_in[13:0]),
    .cin_i(c_in), .carry_o(c0));

  // 64 bits, radix 8: a power of the radix
  hlc_carry_tree #(.WIDTH(64), .RADIX(8)) u1 (
    .clk(clk), .rst(rst), .prop_i(p_in), .gen_i(g_in),
    .cin_i(c_in), .carry_o(c1));

  // 10 bits, radix 3: levels leave single-signal remainders
  hlc_carry_tree #(.WIDTH(10), .RADIX(3)) u2 (
    .clk(clk), .rst(rst), .prop_i(p_in[9:0]), .gen_i(g_in[9:0]),
    .cin_i(c_in), .carry_o(c2));

  function automatic logic [64:0] ref_carry(input logic [63:0] p, input logic [63:0] g,
                                            input logic c, input int m);
    logic [64:0] r;
    r = '0;
    r[0] = c;
    for (int i = 0; i < m; i++)
      r[i+1] = g[i] | (p[i] & r[i]);
    return r;
  endfunction

  task automatic cmp(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_check++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare all three instances against the ripple model of the applied inputs
  task automatic check_all(input string tag, input logic [63:0] p, input logic [63:0] g,
                           input logic c);
    cmp({tag, " R8 u0(14,3)"}, {50'b0, c0}, ref_carry(p, g, c, 14));
    cmp({tag, " R8 u1(64,8)"}, c1,           ref_carry(p, g, c, 64));
    cmp({tag, " R9 u2(10,3)"}, {54'b0, c2}, ref_carry(p, g, c, 10));
  endtask

  task automatic apply(input string tag, input logic [63:0] p, input logic [63:0] g,
                       input logic c);
    @(negedge clk);
    p_in = p; g_in = g; c_in = c;
    @(negedge clk);
    check_all(tag, p, g, c);
  endtask

  initial begin : wd
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_check++;
      n_fail++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_check, n_fail);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    logic [63:0] rp, rg;
    logic rc;
    seed = 32'd20250611;
    void'($urandom(seed));

    // R1: reset clears all carries, even with active inputs
    p_in = '1; g_in = '1; c_in = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1 reset u0", {50'b0, c0}, '0);
    cmp("R1 reset u1", c1, '0);
    cmp("R1 reset u2", {54'b0, c2}, '0);
    @(negedge clk);
    rst = 1'b0;

    // R4: all propagate, no generate
    apply("R4 allprop cin1", '1, '0, 1'b1);
    apply("R4 allprop cin0", '1, '0, 1'b0);
    // R5: all generate
    apply("R5 allgen cin0", '0, '1, 1'b0);
    apply("R5 allgen cin1", '1, '1, 1'b1);
    // R6: neither
    apply("R6 allkill cin1", '0, '0, 1'b1);
    // R3: alternating patterns
    apply("R3 alt a", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0);
    apply("R3 alt b", 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
    // R7: generate at bit 0 travelling to the carry-out
    apply("R7 carryout", ~64'd1, 64'd1, 1'b0);
    // R2: carry-in visible at position 0 with kill everywhere
    apply("R2 cin pass", '0, '0, 1'b1);

    // R1: reset in the middle of traffic
    @(negedge clk);
    rst = 1'b1;
    p_in = '1; g_in = '0; c_in = 1'b1;
    @(negedge clk);
    cmp("R1 midreset u0", {50'b0, c0}, '0);
    cmp("R1 midreset u1", c1, '0);
    cmp("R1 midreset u2", {54'b0, c2}, '0);
    rst = 1'b0;

    // R3 / R2: random traffic, biased towards long propagate runs
    for (int t = 0; t < 400; t++) begin
      rp = {$urandom, $urandom} | {$urandom, $urandom};
      rg = {$urandom, $urandom} & {$urandom, $urandom} & ~rp;
      if (t % 4 == 0) rg = {$urandom, $urandom};
      rc = 1'($urandom);
      apply("R3 random", rp, rg, rc);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_check, n_fail);
    $finish;
  end

endmodule